// File: doc/BRIEF.md
# Byte-Lane Parity Generator and Checker

This block covers data integrity on a 32-bit bus that is split into four byte lanes. On the write side it produces one even-parity bit per lane. Each bit comes straight from the data word, so it is valid in the same cycle as the data the bus master drives. When the write-drive qualifier is low, the parity outputs are held at zero.

On the read side the block checks the returned lane parity bits against the data at every clock edge where the read-ready strobe is low. It reports the result on a single active-low status output in the following clock. Only lanes that take part in the transfer are checked. The active-low byte enables select the lanes, and two active-low bus-width inputs narrow that selection further. A 16-bit port limits the check to the two low lanes. An 8-bit port limits it to the lowest enabled lane. The status is for reporting only, and the block starts no action of its own.

Top module: `lane_parity_unit`

## Requirements
- R1: While `wr_drive` is high, `par_out[i]` is the even-parity bit of `data_in[8i+7:8i]`, so that byte plus its bit holds an even count of ones; lane 0 is bits 7:0 and lane 3 is bits 31:24.
- R2: `par_out` follows `data_in` in the same cycle with no register in between, so write parity has the same timing as write data.
- R3: While `wr_drive` is low, `par_out` is 4'b0000.
- R4: When `rdy_n` is low at a rising clock edge and a checked lane has an odd count of ones over its byte and its `par_in` bit, `err_n` is low for the clock that follows.
- R5: `err_n` is high in every clock that does not directly follow an edge where `rdy_n` was low and a checked lane failed; with `rdy_n` high, bad parity has no effect.
- R6: A lane whose `byte_en_n` bit is 1 is not checked; with all four bits at 1, `err_n` stays high.
- R7: With `bus16_n` low and `bus8_n` high, only lanes 0 and 1 are checked, and each of them only when its byte enable is active.
- R8: With `bus8_n` low, only the lowest-numbered lane whose byte enable is active is checked.
- R9: When `bus8_n` and `bus16_n` are both low, the 8-bit rule of R8 applies.
- R10: While `rst_n` is low, `err_n` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| data_in | input | 32 | Bus data: write data to protect, or read data to check |
| par_in | input | 4 | Returned parity bits, one per lane |
| wr_drive | input | 1 | High while the block drives write data |
| par_out | output | 4 | Generated even-parity bits, one per lane |
| byte_en_n | input | 4 | Active-low byte enables, bit i for lane i |
| bus16_n | input | 1 | Active low: the port is 16 bits wide |
| bus8_n | input | 1 | Active low: the port is 8 bits wide |
| rdy_n | input | 1 | Active-low read ready; data is sampled at this edge |
| err_n | output | 1 | Active-low parity error status, one clock after ready |

## Verification
The hardest case to reach is one where a lane carries bad parity but that lane is excluded from the check. The 8-bit rule is the trickiest, because the lowest enabled lane depends on the byte enables. Lane 1 must also be masked when both width inputs are low, even though the 16-bit rule alone would include it. The stimulus builds bad parity into one chosen lane and sweeps the byte enables and width inputs around it. Each read has a twin that is identical except for the masking inputs, so that lane is flagged in one setting and ignored in the other.

// File: rtl/lane_parity_pkg.sv
package lane_parity_pkg;

    // Registered state of the read checker.
    typedef struct packed {
        logic err_n;
    } chk_state_t;

    localparam chk_state_t CHK_RESET = '{err_n: 1'b1};

endpackage

// File: rtl/lane_parity_xor.sv
// Reduction XOR over one lane: high when the count of ones is odd.
module lane_parity_xor #(
    parameter int W = 8
) (
    input  logic [W-1:0] bits_in,
    output logic         odd
);
    assign odd = ^bits_in;
endmodule

// File: rtl/lane_check_select.sv
// Picks which lanes take part in a read check from enables and port width.
module lane_check_select #(
    parameter int LANES      = 4,
    parameter int HALF_LANES = 2
) (
    input  logic [LANES-1:0] byte_en_n,
    input  logic             bus16_n,
    input  logic             bus8_n,
    output logic [LANES-1:0] lane_sel
);
    localparam logic [LANES-1:0] HALF_MASK = LANES'((1 << HALF_LANES) - 1);

    logic [LANES-1:0] enabled;
    logic [LANES-1:0] lowest;
    logic             found;

    assign enabled = ~byte_en_n;

    always_comb begin
        lowest = '0;
        found  = 1'b0;
        for (int i = 0; i < LANES; i++) begin
            if (enabled[i] && !found) begin
                lowest[i] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        if (!bus8_n) begin
            lane_sel = lowest;
        end else if (!bus16_n) begin
            lane_sel = enabled & HALF_MASK;
        end else begin
            lane_sel = enabled;
        end
    end
endmodule

// File: rtl/lane_parity_unit.sv
module lane_parity_unit
    import lane_parity_pkg::*;
#(
    parameter int LANE_W     = 8,
    parameter int LANES      = 4,
    parameter int HALF_LANES = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LANES*LANE_W-1:0] data_in,
    input  logic [LANES-1:0]        par_in,
    input  logic                    wr_drive,
    output logic [LANES-1:0]        par_out,
    input  logic [LANES-1:0]        byte_en_n,
    input  logic                    bus16_n,
    input  logic                    bus8_n,
    input  logic                    rdy_n,
    output logic                    err_n
);
    localparam int BUS_W = LANES * LANE_W;

    logic [LANES-1:0] wr_odd;
    logic [LANES-1:0] rd_bad;
    logic [LANES-1:0] lane_sel;

    chk_state_t st_d;
    chk_state_t st_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_parity_xor #(.W(LANE_W)) u_gen (
            .bits_in (data_in[g*LANE_W +: LANE_W]),
            .odd     (wr_odd[g])
        );
        lane_parity_xor #(.W(LANE_W + 1)) u_chk (
            .bits_in ({par_in[g], data_in[g*LANE_W +: LANE_W]}),
            .odd     (rd_bad[g])
        );
    end

    lane_check_select #(
        .LANES      (LANES),
        .HALF_LANES (HALF_LANES)
    ) u_sel (
        .byte_en_n (byte_en_n),
        .bus16_n   (bus16_n),
        .bus8_n    (bus8_n),
        .lane_sel  (lane_sel)
    );

    // Write parity shares the cycle of the data itself; quiet when not driving.
    assign par_out = wr_drive ? wr_odd : '0;

    always_comb begin
        st_d       = st_q;
        st_d.err_n = !(!rdy_n && |(rd_bad & lane_sel));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= CHK_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_n = st_q.err_n;
endmodule

// File: rtl/lane_parity_unit_chk.sv
module lane_parity_unit_chk #(
    parameter int BUS_W = 32,
    parameter int LANES = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic [BUS_W-1:0] data_in,
    input logic             wr_drive,
    input logic [LANES-1:0] par_out,
    input logic [LANES-1:0] byte_en_n,
    input logic             rdy_n,
    input logic             err_n
);
    // R1: the driven word plus its parity bits carries an even count of ones
    a_r1_even_total: assert property (@(posedge clk) disable iff (!rst_n)
        wr_drive |-> (^{data_in, par_out}) == 1'b0);

    // R3: nothing is driven on the parity outputs outside writes
    a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_drive |-> par_out == '0);

    // R5: an error only ever follows a ready edge
    a_r5_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> $past(!rdy_n));

    // R6: an error needs at least one enabled lane at the ready edge
    a_r6_needs_lane: assert property (@(posedge clk) disable iff (!rst_n)
        !err_n |-> $past(byte_en_n != '1));
endmodule

bind lane_parity_unit lane_parity_unit_chk #(
    .BUS_W (BUS_W),
    .LANES (LANES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .data_in   (data_in),
    .wr_drive  (wr_drive),
    .par_out   (par_out),
    .byte_en_n (byte_en_n),
    .rdy_n     (rdy_n),
    .err_n     (err_n)
);

// File: tb/lane_parity_unit_bench.sv
`timescale 1ns/1ps
module lane_parity_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] data_in = '0;
    logic [3:0]  par_in = '0;
    logic        wr_drive = 1'b0;
    logic [3:0]  par_out;
    logic [3:0]  byte_en_n = 4'hF;
    logic        bus16_n = 1'b1;
    logic        bus8_n = 1'b1;
    logic        rdy_n = 1'b1;
    logic        err_n;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic  exp;
        string tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    lane_parity_unit u_lane_parity_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_in   (data_in),
        .par_in    (par_in),
        .wr_drive  (wr_drive),
        .par_out   (par_out),
        .byte_en_n (byte_en_n),
        .bus16_n   (bus16_n),
        .bus8_n    (bus8_n),
        .rdy_n     (rdy_n),
        .err_n     (err_n)
    );

    function automatic logic [3:0] good_par(input logic [31:0] d);
        logic [3:0] p;
        for (int i = 0; i < 4; i++) p[i] = ^d[i*8 +: 8];
        return p;
    endfunction

    function automatic logic [3:0] checked(input logic [3:0] ben,
                                           input logic b16, input logic b8);
        logic [3:0] en;
        en = ~ben;
        if (!b8) begin
            if (en[0])      return 4'b0001;
            else if (en[1]) return 4'b0010;
            else if (en[2]) return 4'b0100;
            else if (en[3]) return 4'b1000;
            else            return 4'b0000;
        end
        if (!b16) return en & 4'b0011;
        return en;
    endfunction

    // One bus clock of read-side stimulus; pushes the err_n expected after the edge.
    task automatic rd_step(input logic [31:0] d, input logic [3:0] flip,
                           input logic [3:0] ben, input logic b16, input logic b8,
                           input logic rdy, input string tag);
        item_t it;
        @(negedge clk);
        wr_drive  = 1'b0;
        data_in   = d;
        par_in    = good_par(d) ^ flip;
        byte_en_n = ben;
        bus16_n   = b16;
        bus8_n    = b8;
        rdy_n     = rdy;
        it.exp = !(!rdy && |(flip & checked(ben, b16, b8)));
        it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic wr_check(input logic [31:0] d, input logic drv, input string tag);
        logic [3:0] exp;
        @(negedge clk);
        rdy_n    = 1'b1;
        data_in  = d;
        wr_drive = drv;
        #1;
        exp = drv ? good_par(d) : 4'b0000;
        checks++;
        if (par_out !== exp) begin
            fails++;
            $display("FAIL %s: par_out=%b expected=%b", tag, par_out, exp);
        end
    endtask

    // Monitor: compares err_n against the scoreboard shortly after each edge.
    initial begin
        item_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                checks++;
                if (err_n !== it.exp) begin
                    fails++;
                    $display("FAIL %s: err_n=%b expected=%b", it.tag, err_n, it.exp);
                end
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        checks++;
        if (err_n !== 1'b1) begin
            fails++;
            $display("FAIL R10: err_n=%b expected=1 in reset", err_n);
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1/R2: write parity for several patterns, same cycle as data
        wr_check(32'h0000_0000, 1'b1, "R1 zeros");
        wr_check(32'h0103_0701, 1'b1, "R1 mixed lanes");
        wr_check(32'hFF80_7F01, 1'b1, "R2 follows data");
        wr_check(32'hDEAD_BEEF, 1'b1, "R1 pattern");
        // R3: no drive, no parity
        wr_check(32'hDEAD_BEEF, 1'b0, "R3 quiet");

        // R4/R5: full width reads
        rd_step(32'h1234_5678, 4'b0000, 4'b0000, 1, 1, 0, "R5 clean read");
        rd_step(32'h1234_5678, 4'b0001, 4'b0000, 1, 1, 0, "R4 lane0 bad");
        rd_step(32'h1234_5678, 4'b0000, 4'b0000, 1, 1, 1, "R5 single clock");
        rd_step(32'hA5A5_0F0F, 4'b1000, 4'b0000, 1, 1, 0, "R4 lane3 bad");
        rd_step(32'hA5A5_0F0F, 4'b1111, 4'b0000, 1, 1, 1, "R5 no ready");
        rd_step(32'hA5A5_0F0F, 4'b1000, 4'b0000, 1, 1, 0, "R4 back to back 1");
        rd_step(32'hA5A5_0F0F, 4'b0100, 4'b0000, 1, 1, 0, "R4 back to back 2");
        // R6: masked by byte enables
        rd_step(32'hCAFE_F00D, 4'b1000, 4'b0111, 1, 1, 0, "R6 lane3 disabled");
        rd_step(32'hCAFE_F00D, 4'b1111, 4'b1111, 1, 1, 0, "R6 none enabled");
        rd_step(32'hCAFE_F00D, 4'b1000, 4'b0111, 1, 1, 1, "R5 idle");
        // R7: 16-bit port
        rd_step(32'h0F0F_F0F0, 4'b0100, 4'b0000, 0, 1, 0, "R7 lane2 ignored");
        rd_step(32'h0F0F_F0F0, 4'b0010, 4'b0000, 0, 1, 0, "R7 lane1 checked");
        rd_step(32'h0F0F_F0F0, 4'b0010, 4'b0010, 0, 1, 0, "R7 lane1 disabled");
        // R8: 8-bit port, lowest enabled lane only
        rd_step(32'h5555_AAAA, 4'b1000, 4'b0011, 1, 0, 0, "R8 lane3 not lowest");
        rd_step(32'h5555_AAAA, 4'b0100, 4'b0011, 1, 0, 0, "R8 lane2 lowest");
        rd_step(32'h5555_AAAA, 4'b0001, 4'b0110, 1, 0, 0, "R8 lane0 lowest");
        // R9: both width inputs low, 8-bit rule wins
        rd_step(32'h0123_4567, 4'b0010, 4'b1100, 0, 0, 0, "R9 lane1 masked");
        rd_step(32'h0123_4567, 4'b0010, 4'b1100, 0, 1, 0, "R7 twin lane1 checked");
        rd_step(32'h0123_4567, 4'b0001, 4'b1100, 0, 0, 0, "R9 lane0 checked");
        rd_step(32'h0123_4567, 4'b0000, 4'b1111, 1, 1, 1, "R5 tail");

        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule